// File: doc/BRIEF.md
# Isolatable Direct-Mapped L1 Cache

This block holds a direct-mapped instruction cache and a direct-mapped data cache for a simple 32-bit processor, both sitting on one line-wide memory port. Each cache keeps a tag, a valid bit and a dirty bit per line. Cacheable reads are served from the cache after any needed refill. Cacheable writes update the cache and are also written through to memory. A dirty victim is written back before its line is refilled.

Two status inputs change how the pair behaves. With the swap input high, a request aimed at one cache is served by the other. With the isolate input high, cacheable data-cache requests never reach memory: reads return whatever the line holds, and writes change the bytes but invalidate the line. Software uses this mode to probe and size the cache. A miss flag output reports the outcome of the most recent cacheable data read. The CPU side takes one request at a time and answers with a one-cycle completion pulse.

Top module: `l1_split_cache`

## Requirements
- R1: After reset the miss flag is 0, no memory request is raised, and every line of both caches is invalid, so the first cacheable access to any index misses.
- R2: A request with `req_nocache` high, or with a length above 4 bytes, bypasses the cache. It makes one memory transfer at the line-aligned address with per-byte enables, and it leaves cache contents and the miss flag unchanged.
- R3: The physical cache used is `req_dsel XOR st_swap`, where `req_dsel` is 1 for data and 0 for instruction. Isolation and miss-flag rules follow the requested cache, not the physical one.
- R4: The line index is address bits [OFF+IDX-1:OFF] and the tag is the bits above them. An access hits only when the indexed line is valid and its stored tag equals the request tag.
- R5: On each cacheable data read the miss flag becomes 1 on a miss and 0 on a hit. Writes, bypassed requests and instruction requests leave it unchanged.
- R6: A cacheable miss that is not isolated fetches the line from memory. It then writes the tag, sets the valid bit and clears the dirty bit. A clean or invalid victim causes no memory write.
- R7: A victim that is both valid and dirty is written back as a full line (all byte enables set) to its old address before the refill.
- R8: A cached write sets the line's dirty bit only if at least one written byte differs from the byte already held.
- R9: Every cacheable write that is not isolated is also sent to memory with enables for exactly the written bytes. Cacheable reads make no memory write.
- R10: While `st_isolate` is high, a cacheable request to the data cache makes no memory transfer of any kind.
- R11: An isolated data write updates the cached bytes and clears that line's valid bit. A later isolated read of the same address returns the written bytes and counts as a miss.
- R12: A memory request holds its valid and address until it is accepted. `req_ready` is a one-cycle pulse, raised only after all writeback, refill and write-through for the request have finished.
- R13: Byte i of `req_wdata` and `req_rdata` (bits [8i+7:8i]) maps to address `req_addr+i`. Line byte k sits in bits [8k+7:8k] of the memory line. A request must not cross a line boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_addr | input | AW | Byte address |
| req_len | input | LEN_W | Byte count, 1 to WORD_BYTES |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dsel | input | 1 | 1 = data cache, 0 = instruction cache |
| req_nocache | input | 1 | Uncached request, goes straight to memory |
| req_wdata | input | WW | Write bytes, byte 0 at the lowest address |
| req_ready | output | 1 | One-cycle completion pulse |
| req_rdata | output | WW | Read bytes, valid while req_ready is high |
| st_swap | input | 1 | Swap the roles of the two caches |
| st_isolate | input | 1 | Isolate the data cache from memory |
| miss_flag | output | 1 | Outcome of the last cacheable data read |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = line write, 0 = line read |
| mem_req_addr | output | AW | Line-aligned address |
| mem_req_be | output | LINE_BYTES | Byte enables for writes |
| mem_req_line | output | LW | Write line |
| mem_rsp_valid | input | 1 | Read line is returned |
| mem_rsp_line | input | LW | Read line |

## Verification
Most wrong internal state in this block first shows up as memory traffic or as a miss flag on a later request that reuses the same index. A tag or valid bit that is wrong shows on the next access to that index, as an extra or missing line read and a miss flag of the wrong value. A dirty bit that is wrong stays hidden until a conflicting tag evicts the line: only then is a full-line write missing or added. Stale data held behind an isolated write or a bypassed write shows in the bytes returned by the next read of that address.

// File: rtl/l1c_pkg.sv
// Shared types for the split L1 cache.
package l1c_pkg;
    // Controller states, in the order a miss walks through them.
    typedef enum logic [3:0] {
        ST_IDLE, ST_LOOK, ST_WB, ST_FILL, ST_FILLW,
        ST_ACC, ST_WT, ST_BYP, ST_BYPW, ST_DONE
    } l1c_state_e;
endpackage

// File: rtl/l1c_store.sv
// One direct-mapped cache array: tags, valid and dirty bits, line data.
// Assumes a single index per cycle. A refill has priority over a byte write.
// Only the valid and dirty bits are reset.
module l1c_store #(
    parameter int NLINES     = 8,
    parameter int LINE_BYTES = 8,
    parameter int TAG_W      = 26,
    localparam int IDX_W     = $clog2(NLINES),
    localparam int LW        = LINE_BYTES * 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [IDX_W-1:0]      idx,
    output logic [TAG_W-1:0]      tag_o,
    output logic                  valid_o,
    output logic                  dirty_o,
    output logic [LW-1:0]         line_o,
    input  logic                  fill_en,
    input  logic [TAG_W-1:0]      fill_tag,
    input  logic [LW-1:0]         fill_line,
    input  logic                  wr_en,
    input  logic [LINE_BYTES-1:0] wr_be,
    input  logic [LW-1:0]         wr_line,
    input  logic                  wr_mark,
    input  logic                  wr_kill
);
    logic [TAG_W-1:0] tags [NLINES];
    logic [LW-1:0]    data [NLINES];
    logic [NLINES-1:0] valid, dirty;

    assign tag_o   = tags[idx];
    assign line_o  = data[idx];
    assign valid_o = valid[idx];
    assign dirty_o = dirty[idx];

    // Line state bits: cleared by reset, set by refill, changed by writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= '0;
            dirty <= '0;
        end else if (fill_en) begin
            valid[idx] <= 1'b1;
            dirty[idx] <= 1'b0;
        end else if (wr_en) begin
            if (wr_kill) begin
                valid[idx] <= 1'b0;
                dirty[idx] <= 1'b0;
            end else if (wr_mark) begin
                dirty[idx] <= 1'b1;
            end
        end
    end

    // Tag and data storage: a whole line on refill, enabled bytes on a write.
    always_ff @(posedge clk) begin
        if (fill_en) begin
            tags[idx] <= fill_tag;
            data[idx] <= fill_line;
        end else if (wr_en) begin
            for (int k = 0; k < LINE_BYTES; k++)
                if (wr_be[k]) data[idx][8*k +: 8] <= wr_line[8*k +: 8];
        end
    end
endmodule

// File: rtl/l1c_lane.sv
// Byte-lane steering between the CPU word and a cache line.
// Assumes off + len <= LINE_BYTES and len <= WORD_BYTES. Purely combinational.
module l1c_lane #(
    parameter int LINE_BYTES = 8,
    parameter int WORD_BYTES = 8,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int LEN_W     = $clog2(WORD_BYTES) + 1,
    localparam int LW        = LINE_BYTES * 8,
    localparam int WW        = WORD_BYTES * 8
) (
    input  logic [OFF_W-1:0]      off,
    input  logic [LEN_W-1:0]      len,
    input  logic [WW-1:0]         wdata,
    input  logic [LW-1:0]         line_in,
    output logic [LINE_BYTES-1:0] be,
    output logic [LW-1:0]         wline,
    output logic [WW-1:0]         rdata
);
    // Place the write word into the line and mark the bytes it covers.
    always_comb begin
        be    = '0;
        wline = '0;
        for (int k = 0; k < LINE_BYTES; k++) begin
            if (k >= int'(off) && k < int'(off) + int'(len) &&
                (k - int'(off)) < WORD_BYTES) begin
                be[k] = 1'b1;
                wline[8*k +: 8] = wdata[8*(k - int'(off)) +: 8];
            end
        end
    end

    // Gather the requested bytes of the line into the read word.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < WORD_BYTES; i++)
            if (i < int'(len) && int'(off) + i < LINE_BYTES)
                rdata[8*i +: 8] = line_in[8*(int'(off) + i) +: 8];
    end
endmodule

// File: rtl/l1_split_cache.sv
// Split instruction/data direct-mapped L1 with cache swap and data isolation.
// Takes one request at a time. The request is captured while idle and
// finished with a one-cycle req_ready. The memory port moves whole lines
// with a valid/ready handshake. A read answer comes later on mem_rsp_valid.
// Assumes power-of-two sizes, LINE_BYTES >= WORD_BYTES, and no request that
// crosses a line.
module l1_split_cache import l1c_pkg::*; #(
    parameter int AW            = 32,
    parameter int CACHE_BYTES   = 64,
    parameter int LINE_BYTES    = 8,
    parameter int WORD_BYTES    = 8,
    parameter int CACHEABLE_MAX = 4,
    localparam int NLINES = CACHE_BYTES / LINE_BYTES,
    localparam int OFF_W  = $clog2(LINE_BYTES),
    localparam int IDX_W  = $clog2(NLINES),
    localparam int TAG_W  = AW - OFF_W - IDX_W,
    localparam int LEN_W  = $clog2(WORD_BYTES) + 1,
    localparam int LW     = LINE_BYTES * 8,
    localparam int WW     = WORD_BYTES * 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [AW-1:0]         req_addr,
    input  logic [LEN_W-1:0]      req_len,
    input  logic                  req_write,
    input  logic                  req_dsel,
    input  logic                  req_nocache,
    input  logic [WW-1:0]         req_wdata,
    output logic                  req_ready,
    output logic [WW-1:0]         req_rdata,
    input  logic                  st_swap,
    input  logic                  st_isolate,
    output logic                  miss_flag,
    output logic                  mem_req_valid,
    input  logic                  mem_req_ready,
    output logic                  mem_req_write,
    output logic [AW-1:0]         mem_req_addr,
    output logic [LINE_BYTES-1:0] mem_req_be,
    output logic [LW-1:0]         mem_req_line,
    input  logic                  mem_rsp_valid,
    input  logic [LW-1:0]         mem_rsp_line
);
    l1c_state_e st;

    logic [AW-1:0]    l_addr;
    logic [LEN_W-1:0] l_len;
    logic [WW-1:0]    l_wdata;
    logic             l_write, l_dsel, l_byp, l_iso, l_phys;
    logic [WW-1:0]    rdata_r;

    logic [TAG_W-1:0] l_tag;
    logic [IDX_W-1:0] l_idx;
    logic [OFF_W-1:0] l_off;
    assign l_tag = l_addr[AW-1 -: TAG_W];
    assign l_idx = l_addr[OFF_W +: IDX_W];
    assign l_off = l_addr[OFF_W-1:0];

    // Per-cache array outputs and controls.
    logic [TAG_W-1:0] s_tag   [2];
    logic [LW-1:0]    s_line  [2];
    logic             s_valid [2];
    logic             s_dirty [2];

    logic             fill_go, acc_go, differ;
    logic [LINE_BYTES-1:0] lane_be;
    logic [LW-1:0]    lane_wline, lane_in;
    logic [WW-1:0]    lane_rdata;

    assign fill_go = (st == ST_FILLW) && mem_rsp_valid;
    assign acc_go  = (st == ST_ACC) && l_write;

    for (genvar c = 0; c < 2; c++) begin : g_cache
        l1c_store #(.NLINES(NLINES), .LINE_BYTES(LINE_BYTES), .TAG_W(TAG_W)) u_store (
            .clk      (clk),
            .rst_n    (rst_n),
            .idx      (l_idx),
            .tag_o    (s_tag[c]),
            .valid_o  (s_valid[c]),
            .dirty_o  (s_dirty[c]),
            .line_o   (s_line[c]),
            .fill_en  (fill_go && (l_phys == 1'(c))),
            .fill_tag (l_tag),
            .fill_line(mem_rsp_line),
            .wr_en    (acc_go && (l_phys == 1'(c))),
            .wr_be    (lane_be),
            .wr_line  (lane_wline),
            .wr_mark  (differ),
            .wr_kill  (l_iso)
        );
    end

    logic [TAG_W-1:0] sel_tag;
    logic [LW-1:0]    sel_line;
    logic             sel_valid, sel_dirty, hit;
    assign sel_tag   = s_tag[l_phys];
    assign sel_line  = s_line[l_phys];
    assign sel_valid = s_valid[l_phys];
    assign sel_dirty = s_dirty[l_phys];
    assign hit       = sel_valid && (sel_tag == l_tag);

    assign lane_in = (st == ST_BYPW) ? mem_rsp_line : sel_line;

    l1c_lane #(.LINE_BYTES(LINE_BYTES), .WORD_BYTES(WORD_BYTES)) u_lane (
        .off    (l_off),
        .len    (l_len),
        .wdata  (l_wdata),
        .line_in(lane_in),
        .be     (lane_be),
        .wline  (lane_wline),
        .rdata  (lane_rdata)
    );

    // Detect whether any enabled byte of the write changes the cached byte.
    always_comb begin
        differ = 1'b0;
        for (int k = 0; k < LINE_BYTES; k++)
            if (lane_be[k] && (sel_line[8*k +: 8] != lane_wline[8*k +: 8]))
                differ = 1'b1;
    end

    // Capture the request and its routing while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l_addr <= '0; l_len <= '0; l_wdata <= '0;
            l_write <= 1'b0; l_dsel <= 1'b0; l_byp <= 1'b0;
            l_iso <= 1'b0; l_phys <= 1'b0;
        end else if (st == ST_IDLE && req_valid) begin
            l_addr  <= req_addr;
            l_len   <= req_len;
            l_wdata <= req_wdata;
            l_write <= req_write;
            l_dsel  <= req_dsel;
            l_byp   <= req_nocache || (int'(req_len) > CACHEABLE_MAX);
            l_iso   <= req_dsel && st_isolate;
            l_phys  <= req_dsel ^ st_swap;
        end
    end

    // Sequence lookup, writeback, refill, access and write-through.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            miss_flag <= 1'b0;
            rdata_r   <= '0;
        end else begin
            case (st)
                ST_IDLE:  if (req_valid) st <= ST_LOOK;
                ST_LOOK: begin
                    if (!l_byp && l_dsel && !l_write) miss_flag <= !hit;
                    if (l_byp)                 st <= ST_BYP;
                    else if (!hit && !l_iso)   st <= (sel_valid && sel_dirty) ? ST_WB : ST_FILL;
                    else                       st <= ST_ACC;
                end
                ST_WB:    if (mem_req_ready) st <= ST_FILL;
                ST_FILL:  if (mem_req_ready) st <= ST_FILLW;
                ST_FILLW: if (mem_rsp_valid) st <= ST_ACC;
                ST_ACC: begin
                    rdata_r <= l_write ? '0 : lane_rdata;
                    st      <= (l_write && !l_iso) ? ST_WT : ST_DONE;
                end
                ST_WT:    if (mem_req_ready) st <= ST_DONE;
                ST_BYP:   if (mem_req_ready) st <= l_write ? ST_DONE : ST_BYPW;
                ST_BYPW: if (mem_rsp_valid) begin
                    rdata_r <= lane_rdata;
                    st      <= ST_DONE;
                end
                ST_DONE:  st <= ST_IDLE;
                default:  st <= ST_IDLE;
            endcase
        end
    end

    assign req_ready = (st == ST_DONE);
    assign req_rdata = rdata_r;

    // Drive the memory port from the current state.
    always_comb begin
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = {l_addr[AW-1:OFF_W], {OFF_W{1'b0}}};
        mem_req_be    = '0;
        mem_req_line  = lane_wline;
        case (st)
            ST_WB: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = {sel_tag, l_idx, {OFF_W{1'b0}}};
                mem_req_be    = '1;
                mem_req_line  = sel_line;
            end
            ST_FILL: mem_req_valid = 1'b1;
            ST_WT: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_be    = lane_be;
            end
            ST_BYP: begin
                mem_req_valid = 1'b1;
                mem_req_write = l_write;
                mem_req_be    = l_write ? lane_be : '0;
            end
            default: ;
        endcase
    end

    // R12
    mreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready);
    // R10
    iso_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !(l_iso && !l_byp));
    // R5
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_LOOK) |=> $stable(miss_flag));
    // R11
    iso_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ACC && l_write && l_iso) |=> !sel_valid);
    // R6
    fill_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_go |=> sel_valid && !sel_dirty && (sel_tag == l_tag));
endmodule

// File: tb/l1_split_cache_test.sv
// Scoreboard bench: the driver queues expected read words, the monitor
// compares them on each completion pulse, and a line memory model counts
// traffic. Sized for the default parameters.
module l1_split_cache_test;
    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, req_dsel = 1'b0, req_nocache = 1'b0;
    logic [31:0] req_addr = '0;
    logic [3:0]  req_len = '0;
    logic [63:0] req_wdata = '0;
    logic req_ready, miss_flag;
    logic [63:0] req_rdata;
    logic st_swap = 1'b0, st_isolate = 1'b0;
    logic mem_req_valid, mem_req_write, mem_req_ready, mem_rsp_valid;
    logic [31:0] mem_req_addr;
    logic [7:0]  mem_req_be;
    logic [63:0] mem_req_line, mem_rsp_line;

    l1_split_cache uut (.*);

    initial forever #5 clk = ~clk;

    typedef struct { bit chk; logic [63:0] exp; string req; } item_t;
    item_t q[$];
    int n = 0, f = 0, mon_n = 0, mon_f = 0;
    int rd_cnt = 0, wr_cnt = 0, full_cnt = 0;
    logic [63:0] mem [128];

    // Memory model: accepts a request one cycle after it appears, answers reads next cycle.
    initial begin
        mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_line = '0;
        for (int i = 0; i < 128; i++)
            for (int k = 0; k < 8; k++) mem[i][8*k +: 8] = 8'(i*8 + k) ^ 8'hA5;
        forever begin
            @(posedge clk);
            mem_rsp_valid <= 1'b0;
            mem_req_ready <= 1'b0;
            if (mem_req_valid && mem_req_ready) begin
                if (mem_req_write) begin
                    for (int k = 0; k < 8; k++)
                        if (mem_req_be[k]) mem[mem_req_addr[9:3]][8*k +: 8] = mem_req_line[8*k +: 8];
                    wr_cnt++;
                    if (&mem_req_be) full_cnt++;
                end else begin
                    mem_rsp_line  <= mem[mem_req_addr[9:3]];
                    mem_rsp_valid <= 1'b1;
                    rd_cnt++;
                end
            end else if (mem_req_valid) mem_req_ready <= 1'b1;
        end
    end

    // Monitor: pop and compare at each completion pulse.
    initial forever begin
        @(negedge clk);
        if (req_ready) begin
            item_t it;
            if (q.size() == 0) begin
                mon_n++; mon_f++;
                $display("FAIL R12 unexpected completion act=1 exp=0");
            end else begin
                it = q.pop_front();
                if (it.chk) begin
                    mon_n++;
                    if (req_rdata !== it.exp) begin
                        mon_f++;
                        $display("FAIL %s rdata act=%h exp=%h", it.req, req_rdata, it.exp);
                    end
                end
            end
        end
    end

    function automatic logic [63:0] mbytes(input logic [31:0] a, input int len);
        logic [63:0] r = '0;
        for (int i = 0; i < len; i++)
            r[8*i +: 8] = mem[7'((a + 32'(i)) >> 3)][8*((a + 32'(i)) & 7) +: 8];
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n++;
        if (!ok) begin
            f++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic access(input logic [31:0] a, input int len, input bit wr, input bit d,
                          input bit nc, input logic [63:0] wd, input logic [63:0] exp, input string req);
        item_t it;
        it.chk = !wr; it.exp = exp; it.req = req;
        q.push_back(it);
        req_addr = a; req_len = 4'(len); req_write = wr; req_dsel = d;
        req_nocache = nc; req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as one failure.
    initial begin
        repeat (20000) @(posedge clk);
        $display("FAIL watchdog act=hung exp=done");
        $display("[TB] %0d tests run, %0d failed", n + mon_n + 1, f + mon_f + 1);
        $finish;
    end

    initial begin
        int r0, w0, fw0;
        logic [63:0] old;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(miss_flag == 1'b0 && !req_ready && !mem_req_valid, "R1 reset", {61'b0, miss_flag, req_ready, mem_req_valid}, 0);

        // R1 R4 R6 R13 first read misses and refills
        r0 = rd_cnt;
        access(32'h100, 4, 0, 1, 0, 0, mbytes(32'h100, 4), "R6 refill read");
        check(miss_flag == 1'b1, "R1 R5 miss flag on cold read", 64'(miss_flag), 1);
        check(rd_cnt == r0 + 1, "R6 one line read", 64'(rd_cnt - r0), 1);

        // R4 hit at an offset inside the line
        r0 = rd_cnt;
        access(32'h102, 2, 0, 1, 0, 0, mbytes(32'h102, 2), "R13 offset hit read");
        check(miss_flag == 1'b0 && rd_cnt == r0, "R4 R5 hit", {miss_flag, 63'(rd_cnt - r0)}, 0);

        // R8 R9 write of identical bytes: write-through, line stays clean
        w0 = wr_cnt; fw0 = full_cnt;
        access(32'h100, 4, 1, 1, 0, mbytes(32'h100, 4), 0, "R9");
        check(wr_cnt == w0 + 1 && miss_flag == 1'b0, "R9 R5 write-through, flag kept", 64'(wr_cnt - w0), 1);
        access(32'h140, 4, 0, 1, 0, 0, mbytes(32'h140, 4), "R6 conflict read");
        check(full_cnt == fw0, "R8 clean victim not written back", 64'(full_cnt - fw0), 0);

        // R7 R9 changed bytes make the line dirty; eviction writes it back
        w0 = wr_cnt;
        access(32'h140, 4, 1, 1, 0, 64'hDEADBEEF, 0, "R9");
        check(mbytes(32'h140, 4) == 64'hDEADBEEF && wr_cnt == w0 + 1, "R9 write reaches memory", mbytes(32'h140, 4), 64'hDEADBEEF);
        fw0 = full_cnt;
        access(32'h180, 4, 0, 1, 0, 0, mbytes(32'h180, 4), "R7 read after eviction");
        check(full_cnt == fw0 + 1, "R7 dirty victim written back", 64'(full_cnt - fw0), 1);
        access(32'h184, 4, 0, 1, 0, 0, mbytes(32'h184, 4), "R4 hit");

        // R10 R11 isolated write then isolated read
        st_isolate = 1'b1;
        w0 = wr_cnt; r0 = rd_cnt;
        access(32'h180, 4, 1, 1, 0, 64'h11223344, 0, "R11");
        access(32'h180, 4, 0, 1, 0, 0, 64'h11223344, "R11 isolated bytes kept");
        check(miss_flag == 1'b1, "R11 line invalidated", 64'(miss_flag), 1);
        check(wr_cnt == w0 && rd_cnt == r0, "R10 no memory traffic", 64'(wr_cnt - w0 + rd_cnt - r0), 0);
        st_isolate = 1'b0;
        r0 = rd_cnt; fw0 = full_cnt;
        access(32'h180, 4, 0, 1, 0, 0, mbytes(32'h180, 4), "R10 memory kept old bytes");
        check(rd_cnt == r0 + 1 && full_cnt == fw0, "R11 refill, no writeback", 64'(rd_cnt - r0), 1);

        // R3 R5 instruction access leaves the flag, swap serves data from the other cache
        access(32'h200, 4, 0, 0, 0, 0, mbytes(32'h200, 4), "R3 instruction read");
        check(miss_flag == 1'b1, "R5 instruction read leaves flag", 64'(miss_flag), 1);
        st_swap = 1'b1; r0 = rd_cnt;
        access(32'h200, 4, 0, 1, 0, 0, mbytes(32'h200, 4), "R3 swapped read");
        check(rd_cnt == r0 && miss_flag == 1'b0, "R3 swapped data read hits", 64'(rd_cnt - r0), 0);
        st_swap = 1'b0;

        // R2 long read bypasses without filling; the same line then misses
        r0 = rd_cnt;
        access(32'h300, 8, 0, 1, 0, 0, mbytes(32'h300, 8), "R2 long read");
        check(rd_cnt == r0 + 1 && miss_flag == 1'b0, "R2 bypass read, flag kept", 64'(rd_cnt - r0), 1);
        access(32'h300, 4, 0, 1, 0, 0, mbytes(32'h300, 4), "R2 cached read");
        check(miss_flag == 1'b1, "R2 bypass did not fill", 64'(miss_flag), 1);

        // R2 uncached write reaches memory only; the cached copy stays old
        old = mbytes(32'h304, 4); w0 = wr_cnt;
        access(32'h304, 4, 1, 1, 1, 64'hCAFEF00D, 0, "R2");
        check(wr_cnt == w0 + 1 && mbytes(32'h304, 4) == 64'hCAFEF00D, "R2 uncached write", mbytes(32'h304, 4), 64'hCAFEF00D);
        access(32'h304, 4, 0, 1, 0, 0, old, "R2 cache untouched by bypass");

        $display("[TB] %0d tests run, %0d failed", n + mon_n, f + mon_f);
        $finish;
    end
endmodule